// File: doc/BRIEF.md
# Predicated Saturating Lane MAC Unit

This block is a row of identical lanes, each holding a signed 32-bit accumulator. One command per cycle selects an operation for the whole row. The operation reads one operand row (minimum, maximum) or two (multiply-accumulate), or only the accumulators themselves (shift, clear). A bank of eight lane-mask registers decides which lanes a command may change. Lanes whose mask bit is clear keep their accumulator.

Byte multiply-accumulate finishes on the clock edge that accepts it. Halfword multiply-accumulate passes through a small controller with three states. `ST_IDLE` accepts commands. An accepted halfword command moves it to `ST_WIDE_MUL`, where the captured operands are multiplied. The next edge moves it to `ST_WIDE_SUM`, and the edge after that adds the products into the accumulators and returns to `ST_IDLE`. `busy` is high in both non-idle states, and any command offered then is dropped. Every accumulation clamps at the signed 32-bit limits instead of wrapping.

Each lane takes a 16-bit field from each operand row; lane k uses bits [16k+15:16k]. Operands are read as signed or unsigned according to `sign_a` and `sign_b`, so one signed multiplier covers both forms.

Top module: `simd_mac_array`

## Requirements
- R1: After reset every accumulator is 0, `busy` and `done` are 0, and mask registers 1 to 7 hold all ones.
- R2: A command is accepted when `op_valid` is 1 and `busy` is 0. Byte MAC (`op_code` 1) adds the product of the low bytes of the lane's A and B fields on the accepting edge. Each byte is widened to 9 bits with sign extension when its sign flag is 1 and zero extension when it is 0. `done` is 1 for the following cycle. NOP (`op_code` 0) changes nothing and does not raise `done`.
- R3: Halfword MAC (`op_code` 2) takes the full 16-bit fields, widened to 17 bits under the same flag rule. The accumulators change on the third rising edge counting the accepting edge, and `done` is 1 in the cycle after that edge.
- R4: From the accepting edge of a halfword MAC until its result is written, `busy` is 1, commands offered are ignored, and the accumulators do not change.
- R5: A sum above 2147483647 gives 2147483647, and a sum below -2147483648 gives -2147483648, for both MAC widths and for left shift.
- R6: A command changes only the lanes whose bit is set in the mask register chosen by `pred_sel`; bit k of a mask controls lane k. Mask 0 always reads as all ones, and writes to it are ignored.
- R7: Minimum (`op_code` 3) and maximum (`op_code` 4) replace the accumulator with the smaller or larger, as signed values, of itself and the lane's A field widened to 17 bits under `sign_a`.
- R8: Left shift (`op_code` 5) shifts the accumulator by `shift_amt` bits and clamps the result as in R5. Right shift (`op_code` 6) shifts arithmetically by `shift_amt` bits.
- R9: Clear (`op_code` 7) sets the enabled accumulators to 0.
- R10: A halfword MAC uses the mask and operands present on its accepting edge. A mask write made while it is in flight does not change which lanes it updates.
- R11: A write with `pred_we` 1 stores `pred_wdata` into register `pred_waddr` on the clock edge. A command on that same edge uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Command offered this cycle |
| op_code | input | 3 | Operation selector (see requirements) |
| pred_sel | input | 3 | Mask register used by the command |
| sign_a | input | 1 | Treat A operands as signed |
| sign_b | input | 1 | Treat B operands as signed |
| shift_amt | input | 5 | Shift distance for shift commands |
| op_a | input | LANES*16 | Operand row A, 16 bits per lane |
| op_b | input | LANES*16 | Operand row B, 16 bits per lane |
| pred_we | input | 1 | Mask register write enable |
| pred_waddr | input | 3 | Mask register written |
| pred_wdata | input | LANES | Mask value written |
| busy | output | 1 | Halfword MAC in flight; commands refused |
| done | output | 1 | Result of the last command is in the accumulators |
| acc_out | output | LANES*32 | All accumulators, lane k at bits [32k+31:32k] |

## Verification
The bench builds the block with eight lanes and keeps the default 32-bit accumulator and eight mask registers. With eight lanes, a single mask byte can enable and disable lanes in one command, and every lane can be compared after every command. The 32-bit accumulator keeps the real clamp limits, so three halfword products of 32767 squared, or a left shift of a large value, reach both limits within a few commands. The bench also offers a command and writes a mask while a halfword MAC is in flight, to show that the command is refused and that the mask captured at acceptance is used.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_MAC8  = 3'd1,
        OP_MAC16 = 3'd2,
        OP_MIN   = 3'd3,
        OP_MAX   = 3'd4,
        OP_SHL   = 3'd5,
        OP_SHR   = 3'd6,
        OP_CLR   = 3'd7
    } mac_op_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WIDE_MUL = 2'd1,
        ST_WIDE_SUM = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/mac_pred_bank.sv
module mac_pred_bank #(
    parameter int LANES = 32,
    parameter int NPRED = 8,
    localparam int SELW = $clog2(NPRED)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SELW-1:0]  wr_idx,
    input  logic [LANES-1:0] wr_data,
    input  logic [SELW-1:0]  rd_idx,
    output logic [LANES-1:0] rd_mask
);

    // Entry 0 has no storage: it always reads as all lanes enabled.
    logic [LANES-1:0] store_q [1:NPRED-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 1; k < NPRED; k++) store_q[k] <= '1;
        end else if (wr_en) begin
            for (int k = 1; k < NPRED; k++) begin
                if (wr_idx == SELW'(k)) store_q[k] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_mask = '1;
        for (int k = 1; k < NPRED; k++) begin
            if (rd_idx == SELW'(k)) rd_mask = store_q[k];
        end
    end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    op_valid,
    input  mac_op_e op_code,
    output logic    busy,
    output logic    fire_1c,
    output logic    wide_cap,
    output logic    wide_mul,
    output logic    wide_commit,
    output logic    done
);

    ctrl_state_e state_q, state_d;
    logic        accept;
    logic        done_q;

    assign accept = op_valid && (state_q == ST_IDLE);

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept && op_code == OP_MAC16) state_d = ST_WIDE_MUL;
            ST_WIDE_MUL: state_d = ST_WIDE_SUM;
            ST_WIDE_SUM: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        busy        = 1'b0;
        fire_1c     = 1'b0;
        wide_cap    = 1'b0;
        wide_mul    = 1'b0;
        wide_commit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                fire_1c  = accept && (op_code != OP_MAC16) && (op_code != OP_NOP);
                wide_cap = accept && (op_code == OP_MAC16);
            end
            ST_WIDE_MUL: begin
                busy     = 1'b1;
                wide_mul = 1'b1;
            end
            ST_WIDE_SUM: begin
                busy        = 1'b1;
                wide_commit = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= fire_1c || wide_commit;
    end

    assign done = done_q;

endmodule

// File: rtl/mac_lane.sv
module mac_lane
    import mac_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int DW    = 16,
    localparam int SHW  = $clog2(ACC_W),
    localparam int SW   = 2 * ACC_W,
    localparam int PW   = 2 * DW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mac_op_e          op,
    input  logic             fire,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [SHW-1:0]   shamt,
    input  logic             wide_cap,
    input  logic             wide_en,
    input  logic             wide_mul,
    input  logic             wide_commit,
    output logic [ACC_W-1:0] acc
);

    localparam logic signed [SW-1:0] SAT_HI = {{(ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SW-1:0] SAT_LO = {{(ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

    function automatic logic [ACC_W-1:0] clamp(input logic signed [SW-1:0] v);
        if (v > SAT_HI)      return SAT_HI[ACC_W-1:0];
        else if (v < SAT_LO) return SAT_LO[ACC_W-1:0];
        else                 return v[ACC_W-1:0];
    endfunction

    logic signed [ACC_W-1:0] acc_q, acc_d;
    logic signed [SW-1:0]    acc_w;

    // Byte path: 9x9 signed product
    logic signed [8:0]       a8x, b8x;
    logic signed [17:0]      prod8;
    logic signed [SW-1:0]    prod8_w;

    // Halfword path: operands captured, then multiplied, then summed
    logic signed [DW:0]      wa_q, wb_q;
    logic                    wen_q;
    logic signed [PW-1:0]    wprod_q;
    logic signed [SW-1:0]    wprod_w;

    // Single-row operand for min/max
    logic signed [DW:0]      a_ext;
    logic signed [SW-1:0]    opnd_w;

    assign acc_w   = acc_q;
    assign a8x     = {sign_a & a[7], a[7:0]};
    assign b8x     = {sign_b & b[7], b[7:0]};
    assign prod8   = a8x * b8x;
    assign prod8_w = prod8;
    assign wprod_w = wprod_q;
    assign a_ext   = {sign_a & a[DW-1], a};
    assign opnd_w  = a_ext;

    always_comb begin
        acc_d = acc_q;
        if (wide_commit) begin
            if (wen_q) acc_d = clamp(acc_w + wprod_w);
        end else if (fire) begin
            unique case (op)
                OP_MAC8: acc_d = clamp(acc_w + prod8_w);
                OP_MIN:  acc_d = (opnd_w < acc_w) ? opnd_w[ACC_W-1:0] : acc_q;
                OP_MAX:  acc_d = (opnd_w > acc_w) ? opnd_w[ACC_W-1:0] : acc_q;
                OP_SHL:  acc_d = clamp(acc_w <<< shamt);
                OP_SHR:  acc_d = acc_q >>> shamt;
                OP_CLR:  acc_d = '0;
                default: acc_d = acc_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            wa_q    <= '0;
            wb_q    <= '0;
            wen_q   <= 1'b0;
            wprod_q <= '0;
        end else begin
            acc_q <= acc_d;
            if (wide_cap) begin
                wa_q  <= {sign_a & a[DW-1], a};
                wb_q  <= {sign_b & b[DW-1], b};
                wen_q <= wide_en;
            end
            if (wide_mul) wprod_q <= wa_q * wb_q;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/simd_mac_array.sv
module simd_mac_array
    import mac_pkg::*;
#(
    parameter int LANES = 32,
    parameter int NPRED = 8,
    parameter int DW    = 16,
    parameter int ACC_W = 32,
    localparam int SELW = $clog2(NPRED),
    localparam int SHW  = $clog2(ACC_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [2:0]             op_code,
    input  logic [SELW-1:0]        pred_sel,
    input  logic                   sign_a,
    input  logic                   sign_b,
    input  logic [SHW-1:0]         shift_amt,
    input  logic [LANES*DW-1:0]    op_a,
    input  logic [LANES*DW-1:0]    op_b,
    input  logic                   pred_we,
    input  logic [SELW-1:0]        pred_waddr,
    input  logic [LANES-1:0]       pred_wdata,
    output logic                   busy,
    output logic                   done,
    output logic [LANES*ACC_W-1:0] acc_out
);

    mac_op_e          op_e;
    logic [LANES-1:0] lane_mask;
    logic             fire_1c, wide_cap, wide_mul, wide_commit;

    assign op_e = mac_op_e'(op_code);

    mac_pred_bank #(.LANES(LANES), .NPRED(NPRED)) u_pred (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pred_we),
        .wr_idx  (pred_waddr),
        .wr_data (pred_wdata),
        .rd_idx  (pred_sel),
        .rd_mask (lane_mask)
    );

    mac_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_code     (op_e),
        .busy        (busy),
        .fire_1c     (fire_1c),
        .wide_cap    (wide_cap),
        .wide_mul    (wide_mul),
        .wide_commit (wide_commit),
        .done        (done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mac_lane #(.ACC_W(ACC_W), .DW(DW)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .op          (op_e),
            .fire        (fire_1c & lane_mask[g]),
            .a           (op_a[g*DW +: DW]),
            .b           (op_b[g*DW +: DW]),
            .sign_a      (sign_a),
            .sign_b      (sign_b),
            .shamt       (shift_amt),
            .wide_cap    (wide_cap),
            .wide_en     (lane_mask[g]),
            .wide_mul    (wide_mul),
            .wide_commit (wide_commit),
            .acc         (acc_out[g*ACC_W +: ACC_W])
        );
    end

endmodule

// File: rtl/simd_mac_array_chk.sv
module simd_mac_array_chk
    import mac_pkg::*;
#(
    parameter int LANES = 32,
    parameter int ACC_W = 32,
    parameter int SELW  = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   op_valid,
    input logic [2:0]             op_code,
    input logic [SELW-1:0]        pred_sel,
    input logic                   busy,
    input logic                   done,
    input logic [LANES*ACC_W-1:0] acc_out
);

    logic acc_narrow, acc_wide, acc_nop, acc_clr_all;

    assign acc_narrow  = op_valid && !busy && op_code != OP_MAC16 && op_code != OP_NOP;
    assign acc_wide    = op_valid && !busy && op_code == OP_MAC16;
    assign acc_nop     = op_valid && !busy && op_code == OP_NOP;
    assign acc_clr_all = op_valid && !busy && op_code == OP_CLR && pred_sel == '0;

    AST_NARROW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_narrow |=> (done && !busy)); // R2
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        acc_nop |=> (!done && $stable(acc_out))); // R2
    AST_WIDE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wide |=> (busy && !done) ##1 (busy && !done) ##1 (done && !busy)); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R3
    AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> $stable(acc_out)); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !op_valid) |=> $stable(acc_out)); // R4
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr_all |=> (acc_out == '0)); // R9

endmodule

bind simd_mac_array simd_mac_array_chk #(
    .LANES (LANES),
    .ACC_W (ACC_W),
    .SELW  (SELW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .pred_sel (pred_sel),
    .busy     (busy),
    .done     (done),
    .acc_out  (acc_out)
);

// File: tb/simd_mac_array_bench.sv
module simd_mac_array_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [2:0]        op_code = '0;
    logic [2:0]        pred_sel = '0;
    logic              sign_a = 1'b0, sign_b = 1'b0;
    logic [4:0]        shift_amt = '0;
    logic [NL*16-1:0]  op_a, op_b;
    logic              pred_we = 1'b0;
    logic [2:0]        pred_waddr = '0;
    logic [NL-1:0]     pred_wdata = '0;
    logic              busy, done;
    logic [NL*32-1:0]  acc_out;

    logic [15:0] va [NL];
    logic [15:0] vb [NL];
    longint      mdl [NL];
    logic [NL-1:0] mpred [8];

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            op_a[i*16 +: 16] = va[i];
            op_b[i*16 +: 16] = vb[i];
        end
    end

    simd_mac_array #(.LANES(NL)) u_simd_mac_array (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .pred_sel(pred_sel), .sign_a(sign_a), .sign_b(sign_b), .shift_amt(shift_amt),
        .op_a(op_a), .op_b(op_b), .pred_we(pred_we), .pred_waddr(pred_waddr),
        .pred_wdata(pred_wdata), .busy(busy), .done(done), .acc_out(acc_out)
    );

    function automatic longint sat(longint v);
        if (v > 64'sd2147483647) return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    function automatic longint ext8(logic [7:0] x, logic s);
        if (s && x[7]) return longint'(x) - 256;
        return longint'(x);
    endfunction

    function automatic longint ext16(logic [15:0] x, logic s);
        if (s && x[15]) return longint'(x) - 65536;
        return longint'(x);
    endfunction

    function automatic longint lane_acc(int i);
        return longint'($signed(acc_out[i*32 +: 32]));
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_lanes(string req);
        for (int i = 0; i < NL; i++) check(lane_acc(i) == mdl[i], req, lane_acc(i), mdl[i]);
    endtask

    task automatic model_1c(logic [2:0] op, logic [2:0] ps);
        for (int i = 0; i < NL; i++) begin
            if (mpred[ps][i]) begin
                case (op)
                    3'd1: mdl[i] = sat(mdl[i] + ext8(va[i][7:0], sign_a) * ext8(vb[i][7:0], sign_b));
                    3'd3: if (ext16(va[i], sign_a) < mdl[i]) mdl[i] = ext16(va[i], sign_a);
                    3'd4: if (ext16(va[i], sign_a) > mdl[i]) mdl[i] = ext16(va[i], sign_a);
                    3'd5: mdl[i] = sat(mdl[i] <<< shift_amt);
                    3'd6: mdl[i] = mdl[i] >>> shift_amt;
                    3'd7: mdl[i] = 0;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic write_pred(logic [2:0] idx, logic [NL-1:0] val);
        @(negedge clk);
        pred_we = 1'b1; pred_waddr = idx; pred_wdata = val;
        @(posedge clk);
        if (idx != 0) mpred[idx] = val;
        @(negedge clk);
        pred_we = 1'b0;
    endtask

    // Single-cycle command (also NOP)
    task automatic run1(logic [2:0] op, logic [2:0] ps, string req);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; pred_sel = ps;
        @(posedge clk);
        model_1c(op, ps);
        @(negedge clk);
        op_valid = 1'b0;
        check(done == (op != 3'd0), req, longint'(done), longint'(op != 3'd0));
        check(busy == 1'b0, req, longint'(busy), 0);
        check_lanes(req);
    endtask

    // Halfword MAC; offers a clear and rewrites the chosen mask while in flight
    task automatic run16(logic [2:0] ps);
        logic [NL-1:0] cap_mask;
        longint        prod [NL];
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd2; pred_sel = ps;
        @(posedge clk);
        cap_mask = mpred[ps];
        for (int i = 0; i < NL; i++) prod[i] = ext16(va[i], sign_a) * ext16(vb[i], sign_b);
        @(negedge clk);
        check(busy == 1'b1, "R4 busy after accept", longint'(busy), 1);
        check(done == 1'b0, "R3 no early done", longint'(done), 0);
        check_lanes("R4 hold cycle 1");
        op_code = 3'd7; pred_sel = 3'd0;
        pred_we = 1'b1; pred_waddr = ps; pred_wdata = ~cap_mask;
        @(posedge clk);
        if (ps != 0) mpred[ps] = ~cap_mask;
        @(negedge clk);
        pred_we = 1'b0;
        check(busy == 1'b1, "R4 busy cycle 2", longint'(busy), 1);
        check_lanes("R4 refused clear");
        @(posedge clk);
        for (int i = 0; i < NL; i++) if (cap_mask[i]) mdl[i] = sat(mdl[i] + prod[i]);
        @(negedge clk);
        op_valid = 1'b0;
        check(done == 1'b1, "R3 done after third edge", longint'(done), 1);
        check(busy == 1'b0, "R3 idle after commit", longint'(busy), 0);
        check_lanes("R3 R10 halfword result");
    endtask

    task automatic fill(logic [15:0] a, logic [15:0] b);
        for (int i = 0; i < NL; i++) begin va[i] = a; vb[i] = b; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        for (int k = 0; k < 8; k++) mpred[k] = '1;
        for (int i = 0; i < NL; i++) mdl[i] = 0;
        fill(16'h0000, 16'h0000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R1 busy", longint'(busy), 0);
        check(done == 1'b0, "R1 done", longint'(done), 0);
        check_lanes("R1 reset acc");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: mask register 5 is all ones after reset
        fill(16'h0002, 16'h0003);
        run1(3'd1, 3'd5, "R1 R2 reset mask");

        // R2: signed and unsigned byte products
        fill(16'h00FD, 16'h0005);
        sign_a = 1; sign_b = 1;
        run1(3'd1, 3'd0, "R2 signed byte -3*5");
        sign_a = 0; sign_b = 1;
        run1(3'd1, 3'd0, "R2 unsigned byte 253*5");
        fill(16'h0000, 16'h0000);
        run1(3'd0, 3'd0, "R2 nop");

        // R6 R11: mask write, and mask 0 write ignored
        write_pred(3'd3, 8'b1010_0101);
        fill(16'h0010, 16'h0010);
        sign_a = 1; sign_b = 1;
        run1(3'd1, 3'd3, "R6 R11 masked byte MAC");
        write_pred(3'd0, 8'h00);
        run1(3'd1, 3'd0, "R6 mask 0 stays all ones");

        // R9: masked clear, then full clear
        run1(3'd7, 3'd3, "R9 masked clear");
        run1(3'd7, 3'd0, "R9 clear all");

        // R3 R4 R10: halfword MAC with mask rewritten in flight
        fill(16'hFF00, 16'h0123);
        run16(3'd3);
        // R5: positive clamp
        run1(3'd7, 3'd0, "R9 clear");
        fill(16'h7FFF, 16'h7FFF);
        for (int n = 0; n < 3; n++) run16(3'd0);
        check(lane_acc(0) == 64'sd2147483647, "R5 positive clamp", lane_acc(0), 64'sd2147483647);
        // R5: negative clamp
        run1(3'd7, 3'd0, "R9 clear");
        fill(16'h8000, 16'h7FFF);
        for (int n = 0; n < 3; n++) run16(3'd0);
        check(lane_acc(1) == -64'sd2147483648, "R5 negative clamp", lane_acc(1), -64'sd2147483648);

        // R8: shifts, including left-shift clamp
        shift_amt = 5'd3;
        run1(3'd6, 3'd0, "R8 arithmetic right");
        run1(3'd7, 3'd0, "R9 clear");
        fill(16'h0064, 16'h0064);
        run1(3'd1, 3'd0, "R2 setup");
        shift_amt = 5'd31;
        run1(3'd5, 3'd0, "R5 R8 left shift clamp");

        // R7: min/max against signed and unsigned operand
        fill(16'hFFF0, 16'h0000);
        sign_a = 1;
        run1(3'd3, 3'd0, "R7 min signed");
        sign_a = 0;
        run1(3'd4, 3'd0, "R7 max unsigned");

        // Random mix
        for (int n = 0; n < 300; n++) begin
            logic [2:0] op;
            logic [2:0] ps;
            for (int i = 0; i < NL; i++) begin
                va[i] = 16'($urandom);
                vb[i] = 16'($urandom);
            end
            sign_a = 1'($urandom); sign_b = 1'($urandom);
            shift_amt = 5'($urandom_range(0, 31));
            ps = 3'($urandom);
            op = 3'($urandom);
            if ($urandom_range(0, 9) == 0) write_pred(3'($urandom), NL'($urandom));
            if (op == 3'd2) run16(ps);
            else run1(op, ps, "R2 R5 R6 R7 R8 R9 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule